// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a small bank of programmable windows that map local-bus addresses into PCI bus addresses. Software programs each window through a 32-bit register port: a page-granular base, a page-granular translation target, an extended translation word and an attribute word. The attribute word carries an enable bit and a power-of-two size code.

A 64-bit local address is presented on the lookup port every cycle. One cycle later the block reports whether an enabled window claims the address, which window it is, and the PCI address produced by keeping the offset into the window and adding it to that window's translation target. The storage has one slot more than the reachable windows. Slot 0 is never reachable through the register port and never matches, so window numbers run from 1.

Top module: `owx_xlate`

## Requirements
- R1: After reset every mapped register reads 0 and a lookup reports a miss.
- R2: Window w (1 to 4) occupies offsets 32*w to 32*w+31, so the window number is offset bits [7:5] and offset bits [11:8] are zero. Within a group, byte offset 0x00 holds the translation word, 0x04 the extended translation word, 0x08 the base word and 0x10 the attribute word. A write to one of these offsets is read back unchanged from the same offset in the next cycle.
- R3: Every other offset reads 0, and a write to it changes no register. This covers non-aligned offsets, offsets 0x00 to 0x1F, offsets 0xA0 and above, and the unused words inside a group.
- R4: Attribute bit 31 enables a window. A window whose bit 31 is 0 never matches.
- R5: A window's base is its base word shifted left by 12 bits and zero-extended to 64 bits. Its size is 2 << attribute[5:0] bytes, which gives 2^64 bytes at code 63. An address matches when base <= address < base + size.
- R6: On a match the PCI address is (translation word << 12) + (address - base), modulo 2^64. The extended translation word does not affect the result.
- R7: When no window matches, the hit flag is 0, the window number is 0 and the PCI address is 0.
- R8: When several enabled windows match, the lowest window number is reported.
- R9: The lookup result appears one clock after the address is sampled. A register write in the same cycle as a lookup does not affect that lookup's result. The lookup in the following cycle does see the write.
- R10: Read data is combinational from the offset and reflects a write from the clock edge that ends the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_addr | input | 64 | Local address to translate |
| lk_hit | output | 1 | A window matched the previous cycle's address |
| lk_idx | output | 3 | Number of the matching window, 0 on a miss |
| lk_pci_addr | output | 64 | Translated PCI address, 0 on a miss |

## Verification
A register write and a lookup can land in the same cycle. A write can disable, enable or move the window that the concurrent lookup address falls into. The bench drives both at one clock edge, once turning a window off and once turning it on. It expects the result registered at that edge to follow the old register contents, and a repeat lookup one cycle later to follow the new ones. The size sweep also puts each window at every seventh size code, with probes just inside and just outside both ends, and includes the code whose window reaches the top of the 64-bit space.

// File: rtl/owx_pkg.sv
package owx_pkg;

    localparam int REG_W    = 32;
    localparam int OFS_W    = 12;
    localparam int GRP_LSB  = 5;
    localparam int IDX_W    = 3;
    localparam int PG_SHIFT = 12;
    localparam int SZ_W     = 6;
    localparam int EN_BIT   = 31;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_TRANS,
        FLD_TRANS_EXT,
        FLD_BASE,
        FLD_ATTR
    } owx_fld_e;

    typedef struct packed {
        logic [REG_W-1:0] trans;
        logic [REG_W-1:0] trans_ext;
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] attr;
    } owx_win_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        owx_fld_e         fld;
    } owx_dec_t;

    // Offset decode: group number in [7:5], word select in [4:0].
    function automatic owx_dec_t owx_decode(input logic [OFS_W-1:0] ofs, input int num_win);
        owx_dec_t r;
        r.idx = ofs[GRP_LSB +: IDX_W];
        unique case (ofs[GRP_LSB-1:0])
            5'h00:   r.fld = FLD_TRANS;
            5'h04:   r.fld = FLD_TRANS_EXT;
            5'h08:   r.fld = FLD_BASE;
            5'h10:   r.fld = FLD_ATTR;
            default: r.fld = FLD_NONE;
        endcase
        r.hit = (ofs[OFS_W-1:GRP_LSB+IDX_W] == '0) && (r.idx != '0)
              && (int'(r.idx) <= num_win) && (r.fld != FLD_NONE);
        if (!r.hit) begin
            r.idx = '0;
            r.fld = FLD_NONE;
        end
        return r;
    endfunction

endpackage

// File: rtl/owx_match.sv
module owx_match
    import owx_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              en,
    input  logic [SZ_W-1:0]   size_code,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] trans,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xlated
);

    localparam logic [ADDR_W:0] SPAN_UNIT = (ADDR_W+1)'(2);

    logic [ADDR_W:0] diff;
    logic [ADDR_W:0] span;

    // One extra bit keeps the borrow and the 2^64-byte window.
    always_comb begin
        diff   = {1'b0, addr} - {1'b0, base};
        span   = SPAN_UNIT << size_code;
        hit    = en && !diff[ADDR_W] && (diff < span);
        xlated = trans + diff[ADDR_W-1:0];
    end

endmodule

// File: rtl/owx_prio.sv
module owx_prio
    import owx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 64
) (
    input  logic [NUM_WIN:0]             hit_vec,
    input  logic [NUM_WIN:0][ADDR_W-1:0] xl_vec,
    output logic                         any_hit,
    output logic [IDX_W-1:0]             sel_idx,
    output logic [ADDR_W-1:0]            sel_addr
);

    // Scan from the top down so the lowest matching slot is assigned last.
    always_comb begin
        any_hit  = 1'b0;
        sel_idx  = '0;
        sel_addr = '0;
        for (int i = NUM_WIN; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit  = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_addr = xl_vec[i];
            end
        end
    end

endmodule

// File: rtl/owx_regfile.sv
module owx_regfile
    import owx_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output owx_win_t [NUM_WIN:0] win_o
);

    typedef struct packed {
        owx_win_t [NUM_WIN:1] win;
    } rf_state_t;

    rf_state_t st_d, st_q;
    owx_dec_t  dec;

    always_comb begin
        dec   = owx_decode(ofs, NUM_WIN);
        st_d  = st_q;
        rdata = '0;
        for (int w = 1; w <= NUM_WIN; w++) begin
            if (dec.hit && dec.idx == IDX_W'(w)) begin
                unique case (dec.fld)
                    FLD_TRANS:     rdata = st_q.win[w].trans;
                    FLD_TRANS_EXT: rdata = st_q.win[w].trans_ext;
                    FLD_BASE:      rdata = st_q.win[w].base;
                    FLD_ATTR:      rdata = st_q.win[w].attr;
                    default:       rdata = '0;
                endcase
                if (we) begin
                    unique case (dec.fld)
                        FLD_TRANS:     st_d.win[w].trans     = wdata;
                        FLD_TRANS_EXT: st_d.win[w].trans_ext = wdata;
                        FLD_BASE:      st_d.win[w].base      = wdata;
                        FLD_ATTR:      st_d.win[w].attr      = wdata;
                        default:       ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Slot 0 exists only as a constant so window numbers match offsets.
    assign win_o[0] = '0;
    for (genvar g = 1; g <= NUM_WIN; g++) begin : g_win_out
        assign win_o[g] = st_q.win[g];
    end

endmodule

// File: rtl/owx_xlate.sv
module owx_xlate
    import owx_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [63:0]       lk_addr,
    output logic              lk_hit,
    output logic [2:0]        lk_idx,
    output logic [63:0]       lk_pci_addr
);

    localparam int PAD_W = ADDR_W - REG_W - PG_SHIFT;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] pci;
    } lk_res_t;

    owx_win_t [NUM_WIN:0]             win;
    logic     [NUM_WIN:0]             hit_vec;
    logic     [NUM_WIN:0][ADDR_W-1:0] xl_vec;
    logic     [NUM_WIN:0]             en_vec;
    logic                             sel_hit;
    logic     [IDX_W-1:0]             sel_idx;
    logic     [ADDR_W-1:0]            sel_addr;
    lk_res_t                          lk_d, lk_q;

    owx_regfile #(.NUM_WIN(NUM_WIN)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .ofs   (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .win_o (win)
    );

    assign hit_vec[0] = 1'b0;
    assign xl_vec[0]  = '0;
    assign en_vec[0]  = 1'b0;

    for (genvar g = 1; g <= NUM_WIN; g++) begin : g_match
        assign en_vec[g] = win[g].attr[EN_BIT];
        owx_match #(.ADDR_W(ADDR_W)) match_i (
            .en        (win[g].attr[EN_BIT]),
            .size_code (win[g].attr[SZ_W-1:0]),
            .base      ({{PAD_W{1'b0}}, win[g].base, {PG_SHIFT{1'b0}}}),
            .trans     ({{PAD_W{1'b0}}, win[g].trans, {PG_SHIFT{1'b0}}}),
            .addr      (lk_addr),
            .hit       (hit_vec[g]),
            .xlated    (xl_vec[g])
        );
    end

    owx_prio #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) prio_i (
        .hit_vec  (hit_vec),
        .xl_vec   (xl_vec),
        .any_hit  (sel_hit),
        .sel_idx  (sel_idx),
        .sel_addr (sel_addr)
    );

    always_comb begin
        lk_d.hit = sel_hit;
        lk_d.idx = sel_idx;
        lk_d.pci = sel_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign lk_hit      = lk_q.hit;
    assign lk_idx      = lk_q.idx;
    assign lk_pci_addr = lk_q.pci;

endmodule

// File: rtl/owx_xlate_chk.sv
module owx_xlate_chk #(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              lk_hit,
    input logic [2:0]        lk_idx,
    input logic [63:0]       lk_pci_addr,
    input logic [NUM_WIN:0]  en_vec
);

    logic [7:0] en_prev;
    logic       mapped;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev <= '0;
        end else begin
            en_prev <= 8'(en_vec);
        end
    end

    always_comb begin
        mapped = (reg_addr[11:8] == 4'h0) && (reg_addr[7:5] != 3'd0)
              && (int'(reg_addr[7:5]) <= NUM_WIN)
              && ((reg_addr[4:0] == 5'h00) || (reg_addr[4:0] == 5'h04)
               || (reg_addr[4:0] == 5'h08) || (reg_addr[4:0] == 5'h10));
    end

    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> reg_rdata == 32'h0);

    assert_hit_was_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> en_prev[lk_idx]);

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_idx == 3'd0 && lk_pci_addr == 64'h0));

    assert_hit_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_idx != 3'd0 && int'(lk_idx) <= NUM_WIN));

endmodule

bind owx_xlate owx_xlate_chk #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .lk_hit      (lk_hit),
    .lk_idx      (lk_idx),
    .lk_pci_addr (lk_pci_addr),
    .en_vec      (en_vec)
);

// File: tb/owx_xlate_tb_top.sv
module owx_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [63:0] lk_addr;
    logic        lk_hit;
    logic [2:0]  lk_idx;
    logic [63:0] lk_pci_addr;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    logic [31:0] m_tar  [1:4];
    logic [31:0] m_tear [1:4];
    logic [31:0] m_bar  [1:4];
    logic [31:0] m_attr [1:4];

    always #4 clk = ~clk;

    owx_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pci_addr(lk_pci_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int win_of(input logic [11:0] ofs);
        if (ofs[11:8] != 4'h0) return 0;
        if (ofs[7:5] < 3'd1 || ofs[7:5] > 3'd4) return 0;
        if (!(ofs[4:0] == 5'h00 || ofs[4:0] == 5'h04 || ofs[4:0] == 5'h08 || ofs[4:0] == 5'h10)) return 0;
        return int'(ofs[7:5]);
    endfunction

    function automatic logic [31:0] model_rd(input logic [11:0] ofs);
        int w = win_of(ofs);
        if (w == 0) return 32'h0;
        case (ofs[4:0])
            5'h00:   return m_tar[w];
            5'h04:   return m_tear[w];
            5'h08:   return m_bar[w];
            default: return m_attr[w];
        endcase
    endfunction

    task automatic wr(input logic [11:0] ofs, input logic [31:0] d);
        int w = win_of(ofs);
        reg_addr  = ofs;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (w != 0) begin
            case (ofs[4:0])
                5'h00:   m_tar[w]  = d;
                5'h04:   m_tear[w] = d;
                5'h08:   m_bar[w]  = d;
                default: m_attr[w] = d;
            endcase
        end
    endtask

    task automatic rd_check(input logic [11:0] ofs, input string req);
        logic [31:0] e;
        reg_addr = ofs;
        #1;
        e = model_rd(ofs);
        check(reg_rdata === e, req, 64'(reg_rdata), 64'(e));
    endtask

    task automatic ref_lookup(input logic [63:0] a, output logic h, output logic [2:0] ix, output logic [63:0] p);
        h = 1'b0; ix = 3'd0; p = 64'h0;
        for (int w = 4; w >= 1; w--) begin
            logic [63:0] b;
            logic [64:0] sz, d;
            b  = {20'h0, m_bar[w], 12'h0};
            sz = 65'd2 << m_attr[w][5:0];
            d  = {1'b0, a} - {1'b0, b};
            if (m_attr[w][31] && !d[64] && d < sz) begin
                h = 1'b1; ix = 3'(w); p = {20'h0, m_tar[w], 12'h0} + d[63:0];
            end
        end
    endtask

    task automatic lookup(input logic [63:0] a, input string req);
        logic eh; logic [2:0] ei; logic [63:0] ep;
        lk_addr = a;
        @(negedge clk);
        ref_lookup(a, eh, ei, ep);
        check(lk_hit === eh && lk_idx === ei && lk_pci_addr === ep, req,
              {lk_hit, lk_idx, lk_pci_addr[59:0]}, {eh, ei, ep[59:0]});
    endtask

    task automatic prog(input int w, input logic [31:0] tar, input logic [31:0] bar, input logic [31:0] attr);
        wr(12'(w * 32) + 12'h000, tar);
        wr(12'(w * 32) + 12'h008, bar);
        wr(12'(w * 32) + 12'h010, attr);
    endtask

    task automatic disable_all();
        for (int w = 1; w <= 4; w++) wr(12'(w * 32) + 12'h010, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int w = 1; w <= 4; w++) begin
            m_tar[w] = 0; m_tear[w] = 0; m_bar[w] = 0; m_attr[w] = 0;
        end
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; lk_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int w = 1; w <= 4; w++) begin
            rd_check(12'(w * 32) + 12'h000, "R1 reset trans");
            rd_check(12'(w * 32) + 12'h004, "R1 reset ext");
            rd_check(12'(w * 32) + 12'h008, "R1 reset base");
            rd_check(12'(w * 32) + 12'h010, "R1 reset attr");
        end
        lookup(64'h0, "R1 reset lookup miss");

        // R2, R10: write then read back every mapped word
        for (int w = 1; w <= 4; w++) begin
            wr(12'(w * 32) + 12'h000, 32'hA000_0000 | 32'(w));
            wr(12'(w * 32) + 12'h004, 32'hB000_0000 | 32'(w));
            wr(12'(w * 32) + 12'h008, 32'hC000_0000 | 32'(w));
            wr(12'(w * 32) + 12'h010, 32'h0000_0D00 | 32'(w));
        end
        for (int w = 1; w <= 4; w++) begin
            rd_check(12'(w * 32) + 12'h000, "R2 readback trans");
            rd_check(12'(w * 32) + 12'h004, "R2 readback ext");
            rd_check(12'(w * 32) + 12'h008, "R2 readback base");
            rd_check(12'(w * 32) + 12'h010, "R10 readback attr");
        end

        // R3: writes to unmapped offsets change nothing and read zero
        begin
            logic [11:0] bad [7] = '{12'h02C, 12'h000, 12'h010, 12'h0A0, 12'h120, 12'h021, 12'h03C};
            for (int i = 0; i < 7; i++) begin
                wr(bad[i], 32'hFFFF_FFFF);
                rd_check(bad[i], "R3 unmapped reads zero");
            end
            for (int w = 1; w <= 4; w++) begin
                rd_check(12'(w * 32) + 12'h000, "R3 trans untouched");
                rd_check(12'(w * 32) + 12'h004, "R3 ext untouched");
                rd_check(12'(w * 32) + 12'h008, "R3 base untouched");
                rd_check(12'(w * 32) + 12'h010, "R3 attr untouched");
            end
        end

        // R5, R6, R4, R7: size and edge sweep for every window
        for (int w = 1; w <= 4; w++) begin
            disable_all();
            for (int k = 0; k < 10; k++) begin
                logic [5:0]  code;
                logic [31:0] bar, tar;
                logic [63:0] b, lim;
                logic [64:0] sz, e;
                code = 6'(k * 7);
                bar  = 32'h0010_0000 * 32'(w) + 32'h0000_1000 * 32'(k);
                tar  = $urandom;
                prog(w, tar, bar, 32'h8000_0000 | 32'(code));
                b   = {20'h0, bar, 12'h0};
                sz  = 65'd2 << code;
                e   = {1'b0, b} + sz - 65'd1;
                lim = e[64] ? 64'hFFFF_FFFF_FFFF_FFFF : e[63:0];
                lookup(b - 64'd1, "R5 below base");
                lookup(b, "R5 at base");
                lookup(b + sz[64:1], "R6 mid window");
                lookup(lim, "R5 last byte");
                if (lim != 64'hFFFF_FFFF_FFFF_FFFF) lookup(lim + 64'd1, "R7 past end");
                wr(12'(w * 32) + 12'h010, 32'(code));
                lookup(b, "R4 disabled never hits");
            end
        end

        // R6: extended translation word has no effect
        disable_all();
        prog(2, 32'h0ABC_DEF0, 32'h0000_5000, 32'h8000_0010);
        wr(12'h044, 32'hFFFF_FFFF);
        lookup(64'h0000_0000_0500_0123, "R6 ext word ignored");

        // R8: overlapping windows, lowest number wins
        prog(1, 32'h0000_1111, 32'h0002_0000, 32'h8000_0014);
        prog(2, 32'h0000_2222, 32'h0002_0000, 32'h8000_0014);
        prog(3, 32'h0000_3333, 32'h0001_0000, 32'h8000_001F);
        prog(4, 32'h0000_4444, 32'h0002_0000, 32'h8000_0014);
        lookup(64'h0000_0000_2000_0040, "R8 window 1 wins");
        wr(12'h030, 32'h0000_0014);
        lookup(64'h0000_0000_2000_0040, "R8 window 2 wins");
        wr(12'h050, 32'h0000_0014);
        lookup(64'h0000_0000_2000_0040, "R8 window 3 wins");
        wr(12'h070, 32'h0000_001F);
        lookup(64'h0000_0000_2000_0040, "R8 window 4 wins");

        // R9: write and lookup in the same cycle
        disable_all();
        prog(1, 32'h0007_7000, 32'h0003_0000, 32'h8000_000C);
        lk_addr   = 64'h0000_0000_3000_0010;
        reg_addr  = 12'h030;
        reg_wdata = 32'h0000_000C;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        check(lk_hit === 1'b1 && lk_idx === 3'd1, "R9 same-cycle disable sees old",
              {60'h0, lk_hit, lk_idx}, {60'h0, 1'b1, 3'd1});
        m_attr[1] = 32'h0000_000C;
        lookup(64'h0000_0000_3000_0010, "R9 next cycle sees disable");
        reg_addr  = 12'h030;
        reg_wdata = 32'h8000_000C;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        check(lk_hit === 1'b0 && lk_idx === 3'd0 && lk_pci_addr === 64'h0, "R9 same-cycle enable sees old",
              {60'h0, lk_hit, lk_idx}, 64'h0);
        m_attr[1] = 32'h8000_000C;
        lookup(64'h0000_0000_3000_0010, "R9 next cycle sees enable");

        finish_run();
    end

endmodule